// File: doc/BRIEF.md
# SPI Register-Access Target

This block is the slave end of a serial link that lets an external controller read and write a bank of 32-bit registers. The controller lowers chip select and first sends a 32-bit command word. That word holds the transfer direction, a word count for reads, and a start address counted in 32-bit words. What happens next depends on the direction. In a write frame, each complete 32-bit word that follows is written to the register port, and the address goes up by one after each word. In a read frame, the block fetches the requested words from the register port and shifts them out on MISO, starting at the first clock after the command word.

The block runs on its own system clock, which must be at least about eight times the SCLK rate. It samples SCLK, MOSI and chip select through short synchronizers. All register-port traffic is synchronous to the system clock. A register read returns data in the cycle after the request. Raising chip select ends the frame at once, wherever it has reached.

Top module: `spi_reg_target`

## Requirements
- R1: SPI mode 0 is used (SCLK idles low, MOSI is sampled on the rising edge, MISO changes on the falling edge) and every word is sent most significant bit first. In the command word, bit 31 = 1 means write and 0 means read. Bits 30..25 are the read word count, and writes ignore them. Bits 24..4 are the 21-bit start word address. Bits 3..0 carry no meaning.
- R2: In a write frame, each complete payload word produces one write pulse. The pulse carries that word as write data and the address start + n, where n counts payload words from 0.
- R3: A write frame commits at most 64 payload words. Any words after the 64th produce no write pulse.
- R4: When chip select rises, the frame ends. A payload word that is only partly received is never written. The next frame decodes a fresh command word.
- R5: In a read frame with count N, payload word n (n < N) is read from address start + n. It appears on MISO during the 32 SCLK periods that follow the command word plus n words.
- R6: In a read frame, payload words at index N and beyond shift out as all zeros. No more than N read requests are issued, so a count of 0 issues none.
- R7: MISO stays low while the command word is being received and while chip select is high.
- R8: The read request for word 0 is issued at the 28th rising SCLK edge of the frame, when the address field is complete. The request for word n ≥ 1 is issued no later than 8 SCLK periods before that word's first bit is needed on MISO.
- R9: Write and read pulses last one system clock each and are never high together.
- R10: After reset, MISO and both register-port strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from controller |
| mosi_i | input | 1 | Serial data from controller |
| cs_ni | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to controller |
| reg_addr_o | output | 21 | Register word address |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_rdata_i | input | 32 | Register read data, valid the cycle after reg_re_o |

## Verification
Writes are exercised with several frame shapes:
- a single word, which shows the command fields decode correctly;
- a burst with a nonzero count field, which shows the count is ignored on writes and the address steps by one;
- a 66-word burst, which shows the 64-word cap;
- a frame cut off in mid-word, which shows that partial words are dropped.

Reads are exercised with:
- counts of 4, 0 and 63, each followed by extra words, which separate real data from zero padding and check the fetch limit;
- a frame aborted in mid-transfer and then followed by a clean read, which shows the frame restarts correctly.

The position of each read request is measured in SCLK edges. This confirms the prefetch lead.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 21;
  localparam int CNT_W    = 6;
  localparam int DIR_BIT  = 31;
  localparam int CNT_LSB  = 25;
  localparam int ADDR_LSB = 4;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic cs_ni,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o,
  output logic cs_act_o
);
  localparam logic [2:0] IDLE_V = 3'b001;

  logic [2:0] raw;
  logic [2:0] stg [STAGES];
  logic       sclk_q;

  assign raw = {sclk_i, mosi_i, cs_ni};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= IDLE_V;
        else         stg[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= IDLE_V;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= stg[STAGES-1][2];
  end

  assign cs_act_o = !stg[STAGES-1][0];
  assign mosi_o   = stg[STAGES-1][1];
  assign rise_o   = cs_act_o &&  stg[STAGES-1][2] && !sclk_q;
  assign fall_o   = cs_act_o && !stg[STAGES-1][2] &&  sclk_q;
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter int MAX_WORDS = 64,
  localparam int PW_W = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              mosi_i,
  input  logic              cs_act_i,
  output logic              hdr_done_o,
  output logic              word_bound_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SH    = ADDR_LSB;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] ADDR_BIT  = BIT_W'(WORD_W - ADDR_LSB - 1);
  localparam logic [BIT_W-1:0] FETCH_BIT = BIT_W'(WORD_W / 2 - 1);
  localparam logic [PW_W-1:0]  ONE       = PW_W'(1);
  localparam logic [PW_W-1:0]  CAP       = PW_W'(MAX_WORDS);

  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-2:0] rx_q;
  logic [WORD_W-1:0] word_nxt;
  logic              hdr_done_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PW_W-1:0]   pw_q, fetch_q;
  logic              hdr_wr;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] hdr_addr;

  // header bits 31..4 sit in word_nxt[27:0] once the address is complete
  assign word_nxt = {rx_q, mosi_i};
  assign hdr_wr   = word_nxt[DIR_BIT - SH];
  assign hdr_cnt  = word_nxt[CNT_LSB - SH +: CNT_W];
  assign hdr_addr = word_nxt[ADDR_LSB - SH +: ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q       <= '0;
      rx_q        <= '0;
      hdr_done_q  <= 1'b0;
      wr_q        <= 1'b0;
      cnt_q       <= '0;
      addr_q      <= '0;
      pw_q        <= '0;
      fetch_q     <= '0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (!cs_act_i) begin
        bit_q      <= '0;
        rx_q       <= '0;
        hdr_done_q <= 1'b0;
        wr_q       <= 1'b0;
        cnt_q      <= '0;
        pw_q       <= '0;
        fetch_q    <= '0;
      end else if (rise_i) begin
        rx_q  <= word_nxt[WORD_W-2:0];
        bit_q <= bit_q + 1'b1;
        if (!hdr_done_q) begin
          if (bit_q == ADDR_BIT) begin
            wr_q   <= hdr_wr;
            cnt_q  <= hdr_cnt;
            addr_q <= hdr_addr;
            if (!hdr_wr && hdr_cnt != '0) begin
              reg_re_o   <= 1'b1;
              reg_addr_o <= hdr_addr;
              addr_q     <= hdr_addr + 1'b1;
              fetch_q    <= ONE;
            end
          end
          if (bit_q == LAST_BIT) hdr_done_q <= 1'b1;
        end else begin
          if (wr_q && bit_q == LAST_BIT && pw_q < CAP) begin
            reg_we_o    <= 1'b1;
            reg_wdata_o <= word_nxt;
            reg_addr_o  <= addr_q;
            addr_q      <= addr_q + 1'b1;
          end
          // prefetch next word half a word ahead of its first bit
          if (!wr_q && bit_q == FETCH_BIT && fetch_q == pw_q + ONE &&
              fetch_q < PW_W'(cnt_q)) begin
            reg_re_o   <= 1'b1;
            reg_addr_o <= addr_q;
            addr_q     <= addr_q + 1'b1;
            fetch_q    <= fetch_q + ONE;
          end
          if (bit_q == LAST_BIT && pw_q != CAP) pw_q <= pw_q + ONE;
        end
      end
    end
  end

  assign hdr_done_o   = hdr_done_q;
  assign word_bound_o = hdr_done_q && bit_q == '0;
  assign rd_cnt_o     = cnt_q;
endmodule

// File: rtl/spi_reg_tx.sv
module spi_reg_tx
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              cs_act_i,
  input  logic              load_i,
  input  logic              rd_req_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              miso_o
);
  logic [WORD_W-1:0] tx_q, pre_q;
  logic              req_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      pre_q <= '0;
      req_d <= 1'b0;
    end else begin
      req_d <= rd_req_i;
      if (!cs_act_i) begin
        tx_q  <= '0;
        pre_q <= '0;
      end else begin
        if (fall_i && load_i) begin
          tx_q  <= pre_q;
          pre_q <= '0;
        end else if (fall_i) begin
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
        if (req_d) pre_q <= rdata_i;
      end
    end
  end

  assign miso_o = tx_q[WORD_W-1];
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int MAX_WORDS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  output logic              miso_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  logic             rise, fall, mosi_s, cs_act;
  logic             hdr_done, word_bound;
  logic [CNT_W-1:0] rd_cnt;

  spi_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .mosi_i   (mosi_i),
    .cs_ni    (cs_ni),
    .rise_o   (rise),
    .fall_o   (fall),
    .mosi_o   (mosi_s),
    .cs_act_o (cs_act)
  );

  spi_reg_frame #(.MAX_WORDS(MAX_WORDS)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .mosi_i       (mosi_s),
    .cs_act_i     (cs_act),
    .hdr_done_o   (hdr_done),
    .word_bound_o (word_bound),
    .rd_cnt_o     (rd_cnt),
    .reg_addr_o   (reg_addr_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_we_o     (reg_we_o),
    .reg_re_o     (reg_re_o)
  );

  spi_reg_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .cs_act_i (cs_act),
    .load_i   (word_bound),
    .rd_req_i (reg_re_o),
    .rdata_i  (reg_rdata_i),
    .miso_o   (miso_o)
  );
endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk
  import spi_reg_pkg::*;
#(
  parameter int MAX_WORDS = 64,
  localparam int PW_W = $clog2(MAX_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input logic              hdr_done_i,
  input logic [CNT_W-1:0]  rd_cnt_i,
  input logic              miso_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [ADDR_W-1:0] reg_addr_i
);
  localparam logic [PW_W-1:0] CAP = PW_W'(MAX_WORDS);

  logic [PW_W-1:0]   wr_n, rd_n;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_n      <= '0;
      rd_n      <= '0;
      last_addr <= '0;
    end else if (!cs_act_i) begin
      wr_n <= '0;
      rd_n <= '0;
    end else begin
      if (reg_we_i && wr_n != CAP) wr_n <= wr_n + 1'b1;
      if (reg_re_i && rd_n != CAP) rd_n <= rd_n + 1'b1;
      if (reg_we_i || reg_re_i) last_addr <= reg_addr_i;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_re_i));
  // R9
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !reg_we_i);
  // R9
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |=> !reg_re_i);
  // R3
  wr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> wr_n < CAP);
  // R2
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && wr_n != '0) |-> reg_addr_i == last_addr + 1'b1);
  // R5
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && rd_n != '0) |-> reg_addr_i == last_addr + 1'b1);
  // R6
  rd_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |-> rd_n < PW_W'(rd_cnt_i));
  // R7
  hdr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act_i || !hdr_done_i) |-> !miso_i);
endmodule

bind spi_reg_target spi_reg_target_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .hdr_done_i (hdr_done),
  .rd_cnt_i   (rd_cnt),
  .miso_i     (miso_o),
  .reg_we_i   (reg_we_o),
  .reg_re_i   (reg_re_o),
  .reg_addr_i (reg_addr_o)
);

// File: tb/spi_reg_target_test.sv
module spi_reg_target_test;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        cs_n = 1'b1;
  logic        miso;
  logic [20:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we, reg_re;
  logic [31:0] reg_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int edge_cnt = 0;
  int rd_k = 0;
  logic [52:0] exp_wr_q[$];
  logic [20:0] exp_rd_q[$];

  always #4 clk = ~clk;

  spi_reg_target uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk),
    .mosi_i      (mosi),
    .cs_ni       (cs_n),
    .miso_o      (miso),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata)
  );

  function automatic logic [31:0] mem_val(input logic [20:0] a);
    return {11'h2B5, a} ^ 32'h0F0F_0000;
  endfunction

  function automatic logic [31:0] hdr(input logic wr, input logic [5:0] cnt, input logic [20:0] a);
    return {wr, cnt, a, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register port model: data valid the cycle after a read strobe
  always @(posedge clk) if (reg_re) reg_rdata <= mem_val(reg_addr);

  // reference comparison on every clock
  always @(negedge clk) begin : mon
    logic [52:0] e;
    logic [20:0] ea;
    int lim;
    if (rst_ni) begin
      if (reg_we || reg_re) chk(!(reg_we && reg_re), "R9 strobes exclusive", {62'd0, reg_we, reg_re}, 64'd0);
      if (reg_we) begin
        if (exp_wr_q.size() == 0) chk(1'b0, "R3 unexpected write", {11'd0, reg_addr, reg_wdata}, 64'd0);
        else begin
          e = exp_wr_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R2 write addr/data", {11'd0, reg_addr, reg_wdata}, {11'd0, e});
        end
      end
      if (reg_re) begin
        if (exp_rd_q.size() == 0) chk(1'b0, "R6 unexpected read", {43'd0, reg_addr}, 64'd0);
        else begin
          ea = exp_rd_q.pop_front();
          chk(reg_addr == ea, "R5 read addr", {43'd0, reg_addr}, {43'd0, ea});
        end
        lim = (rd_k == 0) ? 28 : 32 * rd_k + 24;
        if (rd_k == 0) chk(edge_cnt == 28, "R8 first fetch edge", edge_cnt, lim);
        else           chk(edge_cnt <= lim, "R8 prefetch lead", edge_cnt, lim);
        rd_k++;
      end
    end
  end

  task automatic spi_bits(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = 31; i > 31 - n; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      edge_cnt++;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_begin();
    edge_cnt = 0;
    rd_k = 0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [5:0] cfield, input int n);
    logic [31:0] r, d;
    for (int k = 0; k < n && k < 64; k++)
      exp_wr_q.push_back({a + 21'(k), 32'hA5000000 + 32'(k) * 32'h0001_0203});
    frame_begin();
    spi_bits(hdr(1'b1, cfield, a), 32, r);
    for (int k = 0; k < n; k++) begin
      d = 32'hA5000000 + 32'(k) * 32'h0001_0203;
      spi_bits(d, 32, r);
    end
    frame_end();
    chk(exp_wr_q.size() == 0, "R2 R3 writes committed", exp_wr_q.size(), 0);
  endtask

  task automatic do_read(input logic [20:0] a, input int cnt, input int extra);
    logic [31:0] r, ex;
    for (int k = 0; k < cnt; k++) exp_rd_q.push_back(a + 21'(k));
    frame_begin();
    spi_bits(hdr(1'b0, 6'(cnt), a), 32, r);
    chk(r == 0, "R7 miso low in header", r, 0);
    for (int k = 0; k < cnt + extra; k++) begin
      spi_bits(32'h3C3C_C3C3, 32, r);
      ex = (k < cnt) ? mem_val(a + 21'(k)) : 32'h0;
      if (k < cnt) chk(r == ex, "R5 read data", r, ex);
      else         chk(r == ex, "R6 overrun zeros", r, ex);
    end
    frame_end();
    chk(exp_rd_q.size() == 0, "R6 read request count", exp_rd_q.size(), 0);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    // R10
    chk(miso == 1'b0, "R10 reset miso", miso, 0);
    chk(reg_we == 1'b0, "R10 reset we", reg_we, 0);
    chk(reg_re == 1'b0, "R10 reset re", reg_re, 0);

    // R1 single word write decode
    do_write(21'h12345, 6'd0, 1);
    // R1 count field ignored on writes, R2 address step
    do_write(21'h00100, 6'h15, 5);
    // R3 66 words, only 64 committed
    do_write(21'h04000, 6'd0, 66);

    // R4 abort mid-word during write
    exp_wr_q.push_back({21'h0ABC0, 32'h1234_5678});
    frame_begin();
    spi_bits(hdr(1'b1, 6'd0, 21'h0ABC0), 32, r);
    spi_bits(32'h1234_5678, 32, r);
    spi_bits(32'hFFFF_FFFF, 13, r);
    cs_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R4 partial word dropped", exp_wr_q.size(), 0);
    chk(miso == 1'b0, "R7 miso low when deselected", miso, 0);

    // R5 R6 R8 read with overrun
    do_read(21'h002A0, 4, 2);
    // R6 zero count
    do_read(21'h1F000, 0, 2);

    // R4 abort during read, then clean read
    exp_rd_q.push_back(21'h00777);
    frame_begin();
    spi_bits(hdr(1'b0, 6'd3, 21'h00777), 32, r);
    spi_bits(32'h0, 10, r);
    cs_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(exp_rd_q.size() == 0, "R4 read abort", exp_rd_q.size(), 0);
    do_read(21'h00777, 1, 1);

    // R5 R8 maximum count
    do_read(21'h1FF00, 63, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule